// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block paces a converter through a regular sequence of conversion slots. When software pulses the start input while the block is idle, it captures its configuration, raises a busy flag and issues a one-cycle start strobe for slot 0. Further strobes follow for slots 1, 2 and so on, up to the programmed last slot. The strobes are spaced by a conversion period built from three small rate fields. The controller then either stops (single mode) or wraps to slot 0 and keeps running (continuous mode) until software asks it to stop.

Each strobe can instead be timed by a pulse from an external switching regulator, so that conversions fall in quiet intervals. This gating only applies while the finest rate field is zero. With any other setting of that field the internal rate timer paces the conversions. All pins are plain control and status signals. Nothing streams through the block, so it has no valid/ready handshake. Every input is sampled on the rising clock edge and every output is registered.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During and after reset, with no start pulse applied, busy, conv_start and seq_end are low and slot_idx is 0.
- R2: With sequencing enabled and cfg_seq_len = n, a single run issues n+1 conversion strobes for slots 0, 1, ... n, in that order, and then drops busy.
- R3: With cfg_seq_en low, a run converts only slot 0, whatever cfg_seq_len holds.
- R4: With cfg_cont high, the run returns to slot 0 after the last slot and continues with no gap in the strobe spacing.
- R5: In timer mode, conv_start rises in the cycle after the start pulse is accepted. Consecutive strobes are exactly P cycles apart, where P = 16 + 16·cfg_rate_hi + 4·cfg_rate_mid + cfg_rate_lo and each of the three rate fields is 2 bits wide. A single run keeps busy high for (n+1)·P cycles.
- R6: When regulator sync is in force (cfg_sync_en high and cfg_rate_lo = 0), each strobe waits for a pulse on reg_sync. The strobe appears in the cycle after that pulse. Pulses that arrive while a conversion is still in progress are ignored.
- R7: When cfg_rate_lo is nonzero, cfg_sync_en has no effect and the rate timer paces the conversions as in R5.
- R8: A stop request lets the conversion in progress finish its period and then returns the block to idle with busy low and slot_idx 0. A stop that arrives while the block waits for a regulator pulse takes effect at the next edge.
- R9: A start pulse received while busy is ignored.
- R10: Configuration inputs are captured when a start is accepted. Changing them during a run does not affect that run.
- R11: seq_end pulses for one cycle when the final slot of a pass completes. In that same cycle a single run shows busy low and slot_idx 0.
- R12: conv_start is a one-cycle pulse and is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cont | input | 1 | 1: continuous sequencing, 0: single pass |
| cfg_seq_en | input | 1 | 1: use cfg_seq_len, 0: slot 0 only |
| cfg_seq_len | input | 4 | Index of the last slot (slot count minus one) |
| cfg_rate_hi | input | 2 | Coarse rate field, weight 16 cycles |
| cfg_rate_mid | input | 2 | Middle rate field, weight 4 cycles |
| cfg_rate_lo | input | 2 | Fine rate field, weight 1 cycle; nonzero disables sync |
| cfg_sync_en | input | 1 | Pace strobes by reg_sync pulses |
| sw_start | input | 1 | Start pulse, accepted only when idle |
| sw_stop | input | 1 | Stop request |
| reg_sync | input | 1 | Pulse from the switching regulator |
| conv_start | output | 1 | One-cycle conversion start strobe |
| slot_idx | output | 4 | Slot of the current conversion |
| seq_end | output | 1 | One-cycle pulse when the final slot completes |
| busy | output | 1 | A run is in progress |

## Verification
On every cycle, the assertions check the following: strobe width and that strobes occur only while busy, that slot_idx is 0 when idle and never beyond the captured last slot, that seq_end follows only the final slot, that a synchronized strobe always follows a regulator pulse, that the captured configuration stays frozen between starts, and that the timer stays within range. Exact strobe cycles and the period formula can only be shown by the bench scenarios. The same holds for slot order, wrap-around in continuous mode, stop timing, sync being overridden by the fine rate field, and starts or configuration changes having no effect mid-run. The scoreboard compares each strobe and each end pulse against an expected cycle and slot.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  parameter int unsigned LEN_W  = 4;
  parameter int unsigned RATE_W = 2;
  parameter int unsigned BASE   = 16;
  parameter int unsigned WT_HI  = 16;
  parameter int unsigned WT_MID = 4;
  parameter int unsigned WT_LO  = 1;

  localparam int unsigned RMAX    = (1 << RATE_W) - 1;
  localparam int unsigned PER_MAX = BASE + (WT_HI + WT_MID + WT_LO) * RMAX;
  localparam int unsigned CNT_W   = $clog2(PER_MAX + 1);

  typedef logic [CNT_W-1:0]  per_t;
  typedef logic [LEN_W-1:0]  slot_t;
  typedef logic [RATE_W-1:0] rate_t;

  typedef struct packed {
    logic  cont;
    slot_t last;
    logic  sync;
    per_t  period;
  } run_cfg_t;

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_CONV} phase_e;

  function automatic per_t calc_period(rate_t hi, rate_t mid, rate_t lo);
    int unsigned sum;
    sum = BASE + WT_HI * int'(hi) + WT_MID * int'(mid) + WT_LO * int'(lo);
    return per_t'(sum);
  endfunction
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture_i,
  input  logic     cont_i,
  input  logic     seq_en_i,
  input  slot_t    len_i,
  input  rate_t    hi_i,
  input  rate_t    mid_i,
  input  rate_t    lo_i,
  input  logic     sync_en_i,
  output run_cfg_t live_o,
  output run_cfg_t held_o
);
  always_comb begin
    live_o.cont   = cont_i;
    live_o.last   = seq_en_i ? len_i : '0;
    live_o.sync   = sync_en_i && (lo_i == '0);
    live_o.period = calc_period(hi_i, mid_i, lo_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o <= '{cont: 1'b0, last: '0, sync: 1'b0, period: per_t'(BASE)};
    end else if (capture_i) begin
      held_o <= live_o;
    end
  end

  assert_held_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture_i) |-> held_o == $past(held_o));
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  per_t load_val_i,
  output logic expired_o
);
  per_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  assert_timer_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_t'(PER_MAX - 1));
  assert_timer_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     stop_i,
  input  logic     sync_pulse_i,
  input  run_cfg_t cfg_live_i,
  input  run_cfg_t cfg_held_i,
  input  logic     expired_i,
  output logic     capture_o,
  output logic     tmr_load_o,
  output per_t     tmr_val_o,
  output logic     conv_start_o,
  output slot_t    slot_o,
  output logic     seq_end_o,
  output logic     busy_o
);
  phase_e   phase_q;
  slot_t    slot_q;
  logic     stop_q, conv_q, send_q;
  logic     accept, trig, stop_now, done, last_slot, end_run, fire;
  run_cfg_t cfg_cur;

  always_comb begin
    accept    = (phase_q == PH_IDLE) && start_i;
    cfg_cur   = accept ? cfg_live_i : cfg_held_i;
    trig      = !cfg_cur.sync || sync_pulse_i;
    stop_now  = stop_q || stop_i;
    done      = (phase_q == PH_CONV) && expired_i;
    last_slot = (slot_q == cfg_cur.last);
    end_run   = done && (stop_now || (last_slot && !cfg_cur.cont));
    fire      = (accept && trig)
             || ((phase_q == PH_WAIT) && !stop_now && trig)
             || (done && !end_run && trig);
  end

  assign capture_o  = accept;
  assign tmr_load_o = fire;
  assign tmr_val_o  = cfg_cur.period - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      slot_q  <= '0;
      stop_q  <= 1'b0;
      conv_q  <= 1'b0;
      send_q  <= 1'b0;
    end else begin
      conv_q <= fire;
      send_q <= done && last_slot;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            slot_q  <= '0;
            stop_q  <= 1'b0;
            phase_q <= trig ? PH_CONV : PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (stop_now) begin
            phase_q <= PH_IDLE;
            slot_q  <= '0;
            stop_q  <= 1'b0;
          end else if (trig) begin
            phase_q <= PH_CONV;
          end
        end
        PH_CONV: begin
          if (done) begin
            stop_q <= 1'b0;
            if (end_run) begin
              phase_q <= PH_IDLE;
              slot_q  <= '0;
            end else begin
              slot_q  <= last_slot ? '0 : slot_q + 1'b1;
              phase_q <= trig ? PH_CONV : PH_WAIT;
            end
          end else begin
            stop_q <= stop_now;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign conv_start_o = conv_q;
  assign seq_end_o    = send_q;
  assign slot_o       = slot_q;
  assign busy_o       = (phase_q != PH_IDLE);

  assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> busy_o);
  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);
  assert_idle_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> slot_o == '0);
  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> slot_o <= cfg_held_i.last);
  assert_end_final_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end_o |-> $past(slot_q == cfg_held_i.last));
  assert_sync_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> $past(!cfg_cur.sync || sync_pulse_i));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cont,
  input  logic              cfg_seq_en,
  input  logic [LEN_W-1:0]  cfg_seq_len,
  input  logic [RATE_W-1:0] cfg_rate_hi,
  input  logic [RATE_W-1:0] cfg_rate_mid,
  input  logic [RATE_W-1:0] cfg_rate_lo,
  input  logic              cfg_sync_en,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              reg_sync,
  output logic              conv_start,
  output logic [LEN_W-1:0]  slot_idx,
  output logic              seq_end,
  output logic              busy
);
  run_cfg_t cfg_live, cfg_held;
  logic     capture, tmr_load, expired;
  per_t     tmr_val;

  adc_seq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .capture_i(capture),
    .cont_i(cfg_cont), .seq_en_i(cfg_seq_en), .len_i(cfg_seq_len),
    .hi_i(cfg_rate_hi), .mid_i(cfg_rate_mid), .lo_i(cfg_rate_lo),
    .sync_en_i(cfg_sync_en), .live_o(cfg_live), .held_o(cfg_held)
  );

  adc_seq_timer u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
    .load_val_i(tmr_val), .expired_o(expired)
  );

  adc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(sw_start), .stop_i(sw_stop),
    .sync_pulse_i(reg_sync), .cfg_live_i(cfg_live), .cfg_held_i(cfg_held),
    .expired_i(expired), .capture_o(capture), .tmr_load_o(tmr_load),
    .tmr_val_o(tmr_val), .conv_start_o(conv_start), .slot_o(slot_idx),
    .seq_end_o(seq_end), .busy_o(busy)
  );
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       cfg_cont, cfg_seq_en, cfg_sync_en;
  logic [3:0] cfg_seq_len;
  logic [1:0] cfg_rate_hi, cfg_rate_mid, cfg_rate_lo;
  logic       sw_start, sw_stop, reg_sync;
  logic       conv_start, seq_end, busy;
  logic [3:0] slot_idx;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_cont(cfg_cont), .cfg_seq_en(cfg_seq_en),
    .cfg_seq_len(cfg_seq_len), .cfg_rate_hi(cfg_rate_hi),
    .cfg_rate_mid(cfg_rate_mid), .cfg_rate_lo(cfg_rate_lo),
    .cfg_sync_en(cfg_sync_en), .sw_start(sw_start), .sw_stop(sw_stop),
    .reg_sync(reg_sync), .conv_start(conv_start), .slot_idx(slot_idx),
    .seq_end(seq_end), .busy(busy)
  );

  typedef struct { int at; int slot; string tag; } ev_t;
  ev_t q_start[$];
  ev_t q_end[$];
  ev_t e;
  int  cyc = 0;
  int  total = 0, bad = 0;
  bit  fin = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push_s(int at, int slot, string tag);
    q_start.push_back('{at: at, slot: slot, tag: tag});
  endtask

  task automatic push_e(int at, string tag);
    q_end.push_back('{at: at, slot: 0, tag: tag});
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: compares produced strobes and end pulses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      if (conv_start) begin
        if (q_start.size() == 0) chk(1'b0, "R12", "unexpected strobe at cycle", cyc, -1);
        else begin
          e = q_start.pop_front();
          chk(cyc == e.at, e.tag, "strobe cycle", cyc, e.at);
          chk(int'(slot_idx) == e.slot, e.tag, "strobe slot", int'(slot_idx), e.slot);
        end
      end
      if (seq_end) begin
        if (q_end.size() == 0) chk(1'b0, "R11", "unexpected seq_end at cycle", cyc, -1);
        else begin
          e = q_end.pop_front();
          chk(cyc == e.at, e.tag, "seq_end cycle", cyc, e.at);
        end
      end
    end
  end

  task automatic drain(string tag);
    chk(q_start.size() == 0, tag, "missing strobes", q_start.size(), 0);
    chk(q_end.size() == 0, tag, "missing seq_end", q_end.size(), 0);
  endtask

  task automatic set_cfg(bit cont, bit sen, int len, int hi, int mid, int lo, bit sy);
    cfg_cont = cont; cfg_seq_en = sen; cfg_seq_len = 4'(len);
    cfg_rate_hi = 2'(hi); cfg_rate_mid = 2'(mid); cfg_rate_lo = 2'(lo);
    cfg_sync_en = sy;
  endtask

  // single-pass run paced by the timer
  task automatic timer_run(bit sen, int len, int hi, int mid, int lo, bit sy, string tag);
    int n, p, c0;
    n = sen ? len + 1 : 1;
    p = 16 + 16 * hi + 4 * mid + lo;
    @(negedge clk);
    set_cfg(1'b0, sen, len, hi, mid, lo, sy);
    sw_start = 1'b1;
    c0 = cyc;
    for (int k = 0; k < n; k++) push_s(c0 + 1 + k * p, k, tag);
    push_e(c0 + 1 + n * p, "R11");
    @(negedge clk);
    sw_start = 1'b0;
    wait_to(c0 + n * p);
    chk(busy == 1'b1, tag, "busy in last cycle", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, tag, "busy after run", busy, 0);
    chk(slot_idx == 4'd0, "R11", "slot after run", slot_idx, 0);
    @(negedge clk);
    chk(seq_end == 1'b0, "R11", "seq_end width", seq_end, 0);
    repeat (3) @(negedge clk);
    drain(tag);
  endtask

  initial begin
    int c0;
    rst_n = 1'b0; sw_start = 1'b0; sw_stop = 1'b0; reg_sync = 1'b0;
    set_cfg(1'b0, 1'b1, 0, 0, 0, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && conv_start == 1'b0 && seq_end == 1'b0, "R1", "outputs in reset",
        {busy, conv_start, seq_end}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(slot_idx == 4'd0, "R1", "slot after reset", slot_idx, 0);

    timer_run(1'b1, 3, 0, 0, 0, 1'b0, "R2");
    timer_run(1'b0, 5, 0, 0, 0, 1'b0, "R3");
    timer_run(1'b1, 2, 1, 2, 3, 1'b0, "R5");
    timer_run(1'b1, 0, 3, 3, 3, 1'b0, "R5");
    timer_run(1'b1, 1, 0, 0, 1, 1'b1, "R7");

    // R6: regulator-paced strobes, P = 16, two slots
    @(negedge clk);
    set_cfg(1'b0, 1'b1, 1, 0, 0, 0, 1'b1);
    sw_start = 1'b1; c0 = cyc;
    @(negedge clk); sw_start = 1'b0;
    chk(busy == 1'b1, "R6", "busy while waiting", busy, 1);
    wait_to(c0 + 5);
    reg_sync = 1'b1; push_s(c0 + 6, 0, "R6");
    @(negedge clk); reg_sync = 1'b0;
    wait_to(c0 + 10);
    reg_sync = 1'b1;
    @(negedge clk); reg_sync = 1'b0;
    wait_to(c0 + 24);
    chk(slot_idx == 4'd1 && busy == 1'b1, "R6", "waiting on slot 1", int'(slot_idx), 1);
    wait_to(c0 + 26);
    reg_sync = 1'b1; push_s(c0 + 27, 1, "R6"); push_e(c0 + 43, "R6");
    @(negedge clk); reg_sync = 1'b0;
    wait_to(c0 + 43);
    chk(busy == 1'b0, "R6", "busy after sync run", busy, 0);
    repeat (3) @(negedge clk);
    drain("R6");

    // R8: stop while waiting for a regulator pulse
    set_cfg(1'b1, 1'b1, 3, 0, 0, 0, 1'b1);
    sw_start = 1'b1; c0 = cyc;
    @(negedge clk); sw_start = 1'b0;
    wait_to(c0 + 4);
    sw_stop = 1'b1;
    @(negedge clk); sw_stop = 1'b0;
    chk(busy == 1'b0, "R8", "stop while waiting", busy, 1'b0);
    repeat (3) @(negedge clk);
    drain("R8");

    // R4 and R8: continuous, two slots, stop during the second pass
    set_cfg(1'b1, 1'b1, 1, 0, 0, 0, 1'b0);
    sw_start = 1'b1; c0 = cyc;
    push_s(c0 + 1, 0, "R4"); push_s(c0 + 17, 1, "R4");
    push_s(c0 + 33, 0, "R4"); push_s(c0 + 49, 1, "R4");
    push_e(c0 + 33, "R4"); push_e(c0 + 65, "R8");
    @(negedge clk); sw_start = 1'b0;
    wait_to(c0 + 55);
    sw_stop = 1'b1;
    @(negedge clk); sw_stop = 1'b0;
    wait_to(c0 + 64);
    chk(busy == 1'b1, "R8", "busy until slot done", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R8", "idle after stop", busy, 0);
    chk(slot_idx == 4'd0, "R8", "slot after stop", slot_idx, 0);
    repeat (3) @(negedge clk);
    drain("R8");

    // R9 and R10: restart pulse and new configuration during a run
    set_cfg(1'b0, 1'b1, 3, 0, 0, 0, 1'b0);
    sw_start = 1'b1; c0 = cyc;
    for (int k = 0; k < 4; k++) push_s(c0 + 1 + 16 * k, k, "R10");
    push_e(c0 + 65, "R10");
    @(negedge clk); sw_start = 1'b0;
    wait_to(c0 + 10);
    set_cfg(1'b1, 1'b0, 7, 3, 1, 0, 1'b1);
    sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    wait_to(c0 + 20);
    chk(slot_idx == 4'd1, "R9", "slot after ignored start", slot_idx, 1);
    wait_to(c0 + 65);
    chk(busy == 1'b0, "R10", "run length kept", busy, 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9", "no restart", busy, 0);
    drain("R10");

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      total++; bad++;
      $display("FAIL R1 watchdog: got %0d expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule